// File: doc/BRIEF.md
# Calendar Clock with Register Snapshot

This block keeps wall-clock time and calendar date as BCD counters. It is driven by a one-cycle strobe for each cycle of a 32.768 kHz oscillator, already brought into the system clock domain. A prescaler turns the strobes into a 512 Hz square wave and a one-second tick. Each tick advances the chain of seconds, minutes, hours, weekday, day of month, month and two-digit year. Day-of-month rollover follows month length and leap years.

The host sees eight byte-wide registers through a simple synchronous write port and a combinational read port. Address 0 is control. Addresses 1 to 7 form a user-side copy of the time fields. With both control bits clear, the copy follows the core one clock behind it. The freeze bit holds the copy so a multi-byte read is coherent. The stage bit makes the copy writable, and clearing it copies the staged values into the core. Fields that are not valid are forced to their minimum during that copy. The core keeps counting throughout, except during the transfer cycle itself.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, the field registers read seconds 00, minutes 00, hours 00, weekday 01, date 01, month 01 and year 00, and control reads 00. The register map is: 0 control (bit 0 freeze, bit 1 stage), 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year.
- R2: While `osc_en_n` is low, `sq_out` toggles once every OSC_HZ/(2*SQ_HZ) strobes, and the seconds count advances once every OSC_HZ strobes.
- R3: While `osc_en_n` is high, strobes are ignored: `sq_out` and every time field hold their values.
- R4: Seconds and minutes count in BCD from 00 to 59 and then wrap to 00 with a carry. Hours wrap from 23 to 00 with a carry, and digit carries such as 09 to 10 are decimal.
- R5: The weekday advances once per day from 1 to 7 and returns to 1.
- R6: The date wraps to 01 after the last day of the month: 30 in months 04, 06, 09 and 11, and 31 in the other months apart from 02. The month then advances, month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R7: Month 02 has 29 days when the year value is divisible by 4, counting 00 as such a year, and 28 days otherwise.
- R8: While the freeze bit is set and the stage bit is clear, the field registers keep the values captured when freeze was set, while the core keeps counting. After freeze is cleared, reads show the live time.
- R9: Writes to addresses 1 to 7 are ignored while the stage bit is clear.
- R10: Writing control with the stage bit clear, while stage is set, loads the staged fields into the core in that cycle. A one-second tick in the same cycle is dropped in favour of the loaded values, and the prescaler is not reset.
- R11: During the load, a field that has a non-decimal digit or is out of range is forced to its minimum: 00 for seconds, minutes, hours and year, and 01 for weekday, month and date. The date is also forced to 01 when it is past the length of the loaded month.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_pulse | input | 1 | One-cycle strobe per oscillator cycle |
| osc_en_n | input | 1 | Active-low oscillator enable; high stops the prescaler |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| sq_out | output | 1 | 512 Hz nominal square wave |
| sec_tick | output | 1 | One-cycle pulse on each second advance |

## Verification
Counters change at the edge that samples the last strobe of a second. A load takes effect at the edge that samples the control write. The user-side copy follows the core one edge later, and `reg_rdata` is combinational on that copy. The bench therefore drives strobes and writes at falling edges and returns them low at the next falling edge. It then sets the address and samples one full cycle later, so two rising edges separate any core change from the sample. The square wave is sampled at the falling edge after its strobe. The prescaler position is tracked in the bench, so each second boundary is reached with a known strobe count.

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar #(
  parameter int OSC_HZ = 32768,
  parameter int SQ_HZ  = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_pulse,
  input  logic       osc_en_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sq_out,
  output logic       sec_tick
);
  localparam int HALF  = OSC_HZ / (2 * SQ_HZ);
  localparam int FLIPS = 2 * SQ_HZ;
  localparam int HW    = $clog2(HALF + 1);
  localparam int FW    = $clog2(FLIPS + 1);

  function automatic logic [7:0] b2n(input logic [7:0] b);
    return b[7:4] * 8'd10 + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] binc(input logic [7:0] b);
    return (b[3:0] == 4'd9) ? {b[7:4] + 4'd1, 4'd0} : b + 8'd1;
  endfunction

  function automatic logic [7:0] dim(input logic [7:0] mo, input logic [7:0] yr);
    logic [7:0] y;
    y = b2n(yr);
    case (mo)
      8'h02:                      return (y[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic fit(input logic [7:0] b, input logic [7:0] lo, input logic [7:0] hi);
    logic [7:0] v;
    v = b2n(b);
    return (b[3:0] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  // prescaler
  logic [HW-1:0] pre;
  logic [FW-1:0] flips;
  logic step, half_end;

  assign step     = osc_pulse & ~osc_en_n;
  assign half_end = step && (pre == HW'(HALF - 1));
  assign sec_tick = half_end && (flips == FW'(FLIPS - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre    <= '0;
      flips  <= '0;
      sq_out <= 1'b0;
    end else if (step) begin
      pre <= half_end ? '0 : pre + 1'b1;
      if (half_end) begin
        sq_out <= ~sq_out;
        flips  <= sec_tick ? '0 : flips + 1'b1;
      end
    end

  // core counters
  logic [6:0] c_sec, c_min;
  logic [5:0] c_hr, c_dt;
  logic [2:0] c_dow;
  logic [4:0] c_mo;
  logic [7:0] c_yr;
  logic       rd_lock, wr_en;
  logic [7:0] u  [1:7];
  logic [7:0] cv [1:7];

  logic [7:0] n_sec, n_min, n_hr, n_dt, n_mo, n_yr;
  logic       w_s, w_m, w_h, w_d, w_mo;

  assign n_sec = binc({1'b0, c_sec});
  assign n_min = binc({1'b0, c_min});
  assign n_hr  = binc({2'b0, c_hr});
  assign n_dt  = binc({2'b0, c_dt});
  assign n_mo  = binc({3'b0, c_mo});
  assign n_yr  = (c_yr == 8'h99) ? 8'h00 : binc(c_yr);

  assign w_s  = (c_sec == 7'h59);
  assign w_m  = (c_min == 7'h59);
  assign w_h  = (c_hr == 6'h23);
  assign w_d  = ({2'b0, c_dt} == dim({3'b0, c_mo}, c_yr));
  assign w_mo = (c_mo == 5'h12);

  // load values with clamping
  logic [7:0] l_sec, l_min, l_hr, l_dow, l_dt, l_mo, l_yr;
  assign l_sec = fit(u[1], 8'd0, 8'd59) ? u[1] : 8'h00;
  assign l_min = fit(u[2], 8'd0, 8'd59) ? u[2] : 8'h00;
  assign l_hr  = fit(u[3], 8'd0, 8'd23) ? u[3] : 8'h00;
  assign l_dow = fit(u[4], 8'd1, 8'd7)  ? u[4] : 8'h01;
  assign l_mo  = fit(u[6], 8'd1, 8'd12) ? u[6] : 8'h01;
  assign l_yr  = fit(u[7], 8'd0, 8'd99) ? u[7] : 8'h00;
  assign l_dt  = fit(u[5], 8'd1, b2n(dim(l_mo, l_yr))) ? u[5] : 8'h01;

  logic ctrl_wr, load;
  assign ctrl_wr = reg_wr && (reg_addr == 3'd0);
  assign load    = ctrl_wr && wr_en && !reg_wdata[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_sec <= '0;  c_min <= '0;  c_hr <= '0;
      c_dow <= 3'd1; c_dt <= 6'h01; c_mo <= 5'h01; c_yr <= 8'h00;
    end else if (load) begin
      c_sec <= l_sec[6:0];
      c_min <= l_min[6:0];
      c_hr  <= l_hr[5:0];
      c_dow <= l_dow[2:0];
      c_dt  <= l_dt[5:0];
      c_mo  <= l_mo[4:0];
      c_yr  <= l_yr;
    end else if (sec_tick) begin
      c_sec <= w_s ? '0 : n_sec[6:0];
      if (w_s) begin
        c_min <= w_m ? '0 : n_min[6:0];
        if (w_m) begin
          c_hr <= w_h ? '0 : n_hr[5:0];
          if (w_h) begin
            c_dow <= (c_dow == 3'd7) ? 3'd1 : c_dow + 3'd1;
            c_dt  <= w_d ? 6'h01 : n_dt[5:0];
            if (w_d) begin
              c_mo <= w_mo ? 5'h01 : n_mo[4:0];
              if (w_mo) c_yr <= n_yr;
            end
          end
        end
      end
    end

  // host side
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_lock <= 1'b0;
      wr_en   <= 1'b0;
    end else if (ctrl_wr) begin
      rd_lock <= reg_wdata[0];
      wr_en   <= reg_wdata[1];
    end

  assign cv[1] = {1'b0, c_sec};
  assign cv[2] = {1'b0, c_min};
  assign cv[3] = {2'b0, c_hr};
  assign cv[4] = {5'b0, c_dow};
  assign cv[5] = {2'b0, c_dt};
  assign cv[6] = {3'b0, c_mo};
  assign cv[7] = c_yr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      u[1] <= 8'h00; u[2] <= 8'h00; u[3] <= 8'h00; u[4] <= 8'h01;
      u[5] <= 8'h01; u[6] <= 8'h01; u[7] <= 8'h00;
    end else begin
      for (int i = 1; i <= 7; i++) begin
        if (!rd_lock && !wr_en)
          u[i] <= cv[i];
        else if (wr_en && reg_wr && reg_addr == 3'(i))
          u[i] <= reg_wdata;
      end
    end

  always_comb
    case (reg_addr)
      3'd1:    reg_rdata = u[1];
      3'd2:    reg_rdata = u[2];
      3'd3:    reg_rdata = u[3];
      3'd4:    reg_rdata = u[4];
      3'd5:    reg_rdata = u[5];
      3'd6:    reg_rdata = u[6];
      3'd7:    reg_rdata = u[7];
      default: reg_rdata = {6'd0, wr_en, rd_lock};
    endcase
endmodule

// File: rtl/rtc_calendar_chk.sv
`timescale 1ns/1ps
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_pulse,
  input logic       osc_en_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       sec_tick,
  input logic       sq_out,
  input logic [6:0] c_sec,
  input logic [6:0] c_min,
  input logic [5:0] c_hr,
  input logic [2:0] c_dow,
  input logic [5:0] c_dt,
  input logic [4:0] c_mo,
  input logic [7:0] u_sec,
  input logic       rd_lock,
  input logic       wr_en
);
  // R2
  tick_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (osc_pulse && !osc_en_n));

  // R3
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en_n && !(reg_wr && reg_addr == 3'd0)) |=> ($stable(sq_out) && $stable(c_sec)));

  // R4
  time_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_sec[3:0] <= 4'd9 && c_sec[6:4] <= 3'd5 && c_min[3:0] <= 4'd9 &&
     c_min[6:4] <= 3'd5 && c_hr[3:0] <= 4'd9 && c_hr <= 6'h23));

  // R5
  weekday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_dow >= 3'd1 && c_dow <= 3'd7));

  // R6
  date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_dt != 6'h00 && c_dt[3:0] <= 4'd9 && c_dt <= 6'h31 &&
     c_mo != 5'h00 && c_mo[3:0] <= 4'd9 && c_mo <= 5'h12));

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lock && !wr_en) |=> $stable(u_sec));

  // R10
  stage_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && !reg_wdata[1]) |=> !wr_en);
endmodule

bind rtc_calendar rtc_calendar_chk chk (
  .clk(clk), .rst_n(rst_n), .osc_pulse(osc_pulse), .osc_en_n(osc_en_n),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .sec_tick(sec_tick), .sq_out(sq_out),
  .c_sec(c_sec), .c_min(c_min), .c_hr(c_hr), .c_dow(c_dow),
  .c_dt(c_dt), .c_mo(c_mo), .u_sec(u[1]), .rd_lock(rd_lock), .wr_en(wr_en)
);

// File: tb/rtc_calendar_test.sv
`timescale 1ns/1ps
module rtc_calendar_test;
  localparam int OSC  = 8;
  localparam int SQ   = 2;
  localparam int HALF = OSC / (2 * SQ);

  logic       clk = 1'b0, rst_n = 1'b0, osc_pulse = 1'b0, osc_en_n = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  wire  [7:0] reg_rdata;
  wire        sq_out, sec_tick;

  always #2 clk = ~clk;

  rtc_calendar #(.OSC_HZ(OSC), .SQ_HZ(SQ)) uut (
    .clk(clk), .rst_n(rst_n), .osc_pulse(osc_pulse), .osc_en_n(osc_en_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sq_out(sq_out), .sec_tick(sec_tick)
  );

  int checks = 0, fails = 0, pcount = 0;
  bit done = 0;
  int m [1:7];
  logic [7:0] stg [1:7];

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int cl(input logic [7:0] b, input int mn, input int mx);
    int hi, lo, v;
    hi = int'(b[7:4]);
    lo = int'(b[3:0]);
    v  = hi * 10 + lo;
    return (lo <= 9 && v >= mn && v <= mx) ? v : mn;
  endfunction

  task automatic advance();
    m[1]++;
    if (m[1] == 60) begin
      m[1] = 0; m[2]++;
      if (m[2] == 60) begin
        m[2] = 0; m[3]++;
        if (m[3] == 24) begin
          m[3] = 0;
          m[4] = (m[4] == 7) ? 1 : m[4] + 1;
          m[5]++;
          if (m[5] > mdays(m[6], m[7])) begin
            m[5] = 1; m[6]++;
            if (m[6] == 13) begin m[6] = 1; m[7] = (m[7] + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic apply_stage();
    m[6] = cl(stg[6], 1, 12);
    m[7] = cl(stg[7], 0, 99);
    m[1] = cl(stg[1], 0, 59);
    m[2] = cl(stg[2], 0, 59);
    m[3] = cl(stg[3], 0, 23);
    m[4] = cl(stg[4], 1, 7);
    m[5] = cl(stg[5], 1, mdays(m[6], m[7]));
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic osc(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) osc_pulse = 1'b1;
      @(negedge clk) osc_pulse = 1'b0;
      if (!osc_en_n) begin
        pcount++;
        if (pcount == OSC) begin pcount = 0; advance(); end
      end
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk) begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk) reg_addr = a;
    @(negedge clk) d = reg_rdata;
  endtask

  task automatic check_all(input string req);
    logic [7:0] d;
    for (int i = 1; i <= 7; i++) begin
      rd(3'(i), d);
      chk(req, $sformatf("field %0d", i), int'(d), int'(bcd(m[i])));
    end
  endtask

  task automatic load_stage();
    wr(3'd0, 8'h02);
    for (int i = 1; i <= 7; i++) wr(3'(i), stg[i]);
    wr(3'd0, 8'h00);
    apply_stage();
  endtask

  task automatic put(input int s, input int mi, input int h, input int dw,
                     input int dt, input int mo, input int y);
    stg[1] = bcd(s); stg[2] = bcd(mi); stg[3] = bcd(h); stg[4] = bcd(dw);
    stg[5] = bcd(dt); stg[6] = bcd(mo); stg[7] = bcd(y);
    load_stage();
  endtask

  task automatic next_sec();
    osc(OSC - pcount);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #700us;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d, a;
    logic [7:0] snap [1:7];
    int unsigned seed;
    seed = $urandom(32'h5eed);
    m[1] = 0; m[2] = 0; m[3] = 0; m[4] = 1; m[5] = 1; m[6] = 1; m[7] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_all("R1");
    rd(3'd0, d); chk("R1", "control", int'(d), 0);
    chk("R1", "sq_out", int'(sq_out), 0);

    // R2 divider
    osc(1);  chk("R2", "sq after 1", int'(sq_out), 0);
    osc(1);  chk("R2", "sq after 2", int'(sq_out), 1);
    osc(OSC - 3); rd(3'd1, d); chk("R2", "sec before tick", int'(d), 0);
    osc(1);  rd(3'd1, d); chk("R2", "sec after tick", int'(d), 1);

    // R3 disabled oscillator
    osc_en_n = 1'b1;
    a = 8'(sq_out);
    osc(3 * OSC);
    chk("R3", "sq held", int'(sq_out), int'(a));
    rd(3'd1, d); chk("R3", "sec held", int'(d), 1);
    osc_en_n = 1'b0;

    // R9 ignored writes
    wr(3'd1, 8'h33);
    rd(3'd1, d); chk("R9", "sec write ignored", int'(d), int'(bcd(m[1])));
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h44);
    rd(3'd2, d); chk("R9", "min write ignored frozen", int'(d), int'(bcd(m[2])));
    wr(3'd0, 8'h00);

    // R4 R5 R6 full wrap
    put(59, 59, 23, 7, 31, 12, 99);
    check_all("R11");
    next_sec();
    check_all("R6");
    rd(3'd4, d); chk("R5", "weekday wrap", int'(d), 1);
    rd(3'd3, d); chk("R4", "hour wrap", int'(d), 0);
    rd(3'd7, d); chk("R6", "year wrap", int'(d), 0);

    put(59, 59, 9, 3, 5, 5, 10);
    next_sec();
    rd(3'd3, d); chk("R4", "hour 09 to 10", int'(d), 8'h10);
    rd(3'd4, d); chk("R5", "weekday step", int'(d), 3);

    // R7 leap handling
    put(59, 59, 23, 2, 28, 2, 24);
    next_sec();
    rd(3'd5, d); chk("R7", "leap 28 to 29", int'(d), 8'h29);
    put(59, 59, 23, 2, 28, 2, 23);
    next_sec();
    rd(3'd5, d); chk("R7", "common feb end", int'(d), 8'h01);
    rd(3'd6, d); chk("R7", "to march", int'(d), 8'h03);
    put(59, 59, 23, 2, 29, 2, 0);
    next_sec();
    rd(3'd6, d); chk("R7", "year 00 feb 29 end", int'(d), 8'h03);

    // R6 month lengths
    put(59, 59, 23, 4, 30, 4, 50);
    next_sec(); check_all("R6");
    rd(3'd6, d); chk("R6", "april end", int'(d), 8'h05);
    put(59, 59, 23, 4, 30, 1, 50);
    next_sec();
    rd(3'd5, d); chk("R6", "jan 30 to 31", int'(d), 8'h31);

    // R8 freeze
    wr(3'd0, 8'h01);
    for (int i = 1; i <= 7; i++) rd(3'(i), snap[i]);
    osc(3 * OSC + 1);
    for (int i = 1; i <= 7; i++) begin
      rd(3'(i), d);
      chk("R8", $sformatf("frozen field %0d", i), int'(d), int'(snap[i]));
    end
    wr(3'd0, 8'h00);
    check_all("R8");

    // R11 clamping
    for (int i = 1; i <= 7; i++) stg[i] = 8'hFF;
    load_stage();
    rd(3'd1, d); chk("R11", "sec FF", int'(d), 0);
    rd(3'd4, d); chk("R11", "weekday FF", int'(d), 1);
    rd(3'd6, d); chk("R11", "month FF", int'(d), 1);
    check_all("R11");
    put(10, 10, 10, 2, 31, 4, 20);
    rd(3'd5, d); chk("R11", "date past month", int'(d), 1);
    stg[1] = 8'h5A; stg[3] = 8'h24; load_stage();
    rd(3'd1, d); chk("R11", "sec 5A", int'(d), 0);
    rd(3'd3, d); chk("R11", "hour 24", int'(d), 0);

    // R10 load colliding with tick
    wr(3'd0, 8'h02);
    stg[1] = 8'h30; stg[2] = 8'h15; stg[3] = 8'h12; stg[4] = 8'h05;
    stg[5] = 8'h17; stg[6] = 8'h08; stg[7] = 8'h42;
    for (int i = 1; i <= 7; i++) wr(3'(i), stg[i]);
    osc(OSC - 1 - pcount);
    @(negedge clk) begin osc_pulse = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h00; end
    @(negedge clk) begin osc_pulse = 1'b0; reg_wr = 1'b0; end
    pcount = 0;
    apply_stage();
    check_all("R10");
    osc(OSC - 1);
    rd(3'd1, d); chk("R10", "no early tick", int'(d), 8'h30);
    osc(1);
    rd(3'd1, d); chk("R10", "next tick", int'(d), 8'h31);

    // random mix
    for (int it = 0; it < 120; it++) begin
      int op;
      op = int'($urandom % 4);
      if (op == 0) begin
        stg[1] = bcd(int'($urandom % 60)); stg[2] = bcd(int'($urandom % 60));
        stg[3] = bcd(int'($urandom % 24)); stg[4] = bcd(int'($urandom % 7) + 1);
        stg[5] = bcd(int'($urandom % 31) + 1); stg[6] = bcd(int'($urandom % 12) + 1);
        stg[7] = bcd(int'($urandom % 100));
        if ($urandom % 8 == 0) stg[int'($urandom % 7) + 1] = 8'($urandom);
        if ($urandom % 3 == 0) begin stg[1] = 8'h59; stg[2] = 8'h59; stg[3] = 8'h23; end
        load_stage();
        check_all("R11");
      end else if (op == 1) begin
        wr(3'd0, 8'h01);
        for (int i = 1; i <= 7; i++) rd(3'(i), snap[i]);
        osc(int'($urandom % (2 * OSC)));
        for (int i = 1; i <= 7; i++) begin
          rd(3'(i), d);
          chk("R8", "random frozen", int'(d), int'(snap[i]));
        end
        wr(3'd0, 8'h00);
        check_all("R8");
      end else begin
        osc_en_n = ($urandom % 5 == 0);
        osc(int'($urandom % (3 * OSC)));
        chk("R2", "random sq", int'(sq_out), (pcount / HALF) % 2);
        osc_en_n = 1'b0;
        check_all("R4");
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule